// File: doc/BRIEF.md
# Dataflow Thread Synchronization Scheduler

This unit keeps the bookkeeping for fine-grain dataflow threads on behalf of one core. A thread is created with a code pointer and the number of input values it must receive before it may run. The unit gives the new thread a slot, which holds the code pointer, a private frame of 64 words of 64 bits, and a counter of inputs still missing. Producers deliver values into a consumer's frame with a write command. Each accepted write lowers that consumer's counter by one. When the counter reaches zero the thread changes from waiting to ready, with no software synchronization involved.

Ready threads enter a first-in first-out queue. The core pops it with a valid/ready handshake and receives the slot handle and the code pointer. A running thread fetches its inputs with read commands and frees its slot and frame with a destroy command. Commands are taken one at a time, and each has a fixed latency. A parameter makes every command finish in a single cycle instead.

Top module: `dft_sched`

## Requirements
- R1: Command codes on `cmd_op` are 0 create, 1 write, 2 read, 3 destroy. A create takes the lowest-numbered free slot and returns its index on `rsp_handle`. The handle selects the thread's frame.
- R2: A thread created with a missing-input count of N enters the ready queue only after its N-th accepted write, and not after fewer writes.
- R3: A write stores `cmd_data` at word `cmd_off` (6 bits, 64 words) of frame `cmd_slot`. A later read of the same slot and offset returns that value on `rsp_data`.
- R4: A create with a count of zero places the thread in the ready queue at once.
- R5: A write to a slot that is not allocated, or to a thread whose count is already zero, raises `rsp_err`. It stores nothing and does not change the counter.
- R6: A create while every slot is in use raises `rsp_nores` and allocates nothing.
- R7: A destroy frees the slot, so a later create can reuse it. A destroy of a slot that is not allocated raises `rsp_err`.
- R8: With default parameters, `rsp_done` first goes high 5 cycles after acceptance for create, 4 for write, 1 for read and 2 for destroy, where the acceptance edge counts as cycle 1. `cmd_ready` stays low until the done cycle.
- R9: With the optimistic-mode parameter set, every command completes in 1 cycle.
- R10: The ready queue hands out threads in the order their counts reached zero, giving slot and code pointer. The head is held stable while `rdy_ready` is low.
- R11: During and right after reset, `cmd_ready` is high, `rdy_valid` is low and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 2 | Command code |
| cmd_slot | input | SW | Target frame handle (write) or own handle (read, destroy) |
| cmd_off | input | OFF_W | Word offset within the frame |
| cmd_data | input | DATA_W | Value to store (write) |
| cmd_ptr | input | PTR_W | Code pointer (create) |
| cmd_cnt | input | CNT_W | Initial missing-input count (create) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_handle | output | SW | Slot given by a create |
| rsp_data | output | DATA_W | Value returned by a read |
| rsp_err | output | 1 | Command refused (bad target) |
| rsp_nores | output | 1 | Create refused, no slot free |
| rdy_valid | output | 1 | Ready queue not empty |
| rdy_ready | input | 1 | Core pops the queue head |
| rdy_slot | output | SW | Handle of the head thread |
| rdy_ptr | output | PTR_W | Code pointer of the head thread |

## Verification
The bench targets these cases:
- A write to a thread whose count is already zero. A design that decremented it anyway would wrap the counter and queue the thread a second time; a design that stored the data would corrupt a frame the bench later reads back.
- A create of a thread that needs no inputs. If the unit waited for a write, that thread would never appear in the queue.
- Slot exhaustion followed by one destroy. The bench checks that only the freed slot comes back, so a picker that skipped holes or handed out a slot it did not have is caught.
- The latency of each command, and whether `cmd_ready` rises early. Either fault shows up as a miscounted cycle.
- The queue order across threads whose counts reach zero in a different order from creation. Returning threads in creation order is caught here.

// File: rtl/dft_pkg.sv
package dft_pkg;

  typedef enum logic [1:0] {
    OP_SCHED   = 2'd0,
    OP_WRITE   = 2'd1,
    OP_READ    = 2'd2,
    OP_DESTROY = 2'd3
  } dft_op_e;

  // Cycle count of one command, acceptance edge included.
  function automatic int unsigned lat_of(logic [1:0] op, bit fast,
                                         int unsigned l_sched, int unsigned l_write,
                                         int unsigned l_read, int unsigned l_destroy);
    if (fast) return 1;
    case (op)
      OP_SCHED: return l_sched;
      OP_WRITE: return l_write;
      OP_READ:  return l_read;
      default:  return l_destroy;
    endcase
  endfunction

endpackage

// File: rtl/dft_cmd_timer.sv
module dft_cmd_timer #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [LAT_W-1:0] lat,
  output logic             cmd_ready,
  output logic             accept,
  output logic             fire_now,
  output logic             fire_late
);
  logic             busy_q, busy_d;
  logic [LAT_W-1:0] rem_q, rem_d;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign fire_now  = accept && (lat == LAT_W'(1));
  assign fire_late = busy_q && (rem_q == '0);

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    if (accept && !fire_now) begin
      busy_d = 1'b1;
      rem_d  = lat - LAT_W'(2);
    end else if (busy_q) begin
      if (rem_q == '0) busy_d = 1'b0;
      else             rem_d  = rem_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (accept || busy_q) begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/dft_slot_pick.sv
module dft_slot_pick #(
  parameter int SLOTS = 16,
  parameter int SW    = 4
) (
  input  logic [SLOTS-1:0] used,
  output logic             found,
  output logic [SW-1:0]    idx
);
  // Lowest free index wins: scan downward so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/dft_ready_fifo.sv
module dft_ready_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign pop_ok    = pop && (cnt_q != '0);
  assign push_ok   = push && ((cnt_q != CW'(DEPTH)) || pop_ok);
  assign out_valid = (cnt_q != '0);
  assign out_data  = store[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = wr_q + AW'(1);
    if (pop_ok)  rd_d = rd_q + AW'(1);
    if (push_ok && !pop_ok) cnt_d = cnt_q + CW'(1);
    if (!push_ok && pop_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push_ok || pop_ok) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_q] <= push_data;
  end
endmodule

// File: rtl/dft_sched.sv
module dft_sched
  import dft_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int FRAME_WORDS = 64,
  parameter int DATA_W      = 64,
  parameter int PTR_W       = 32,
  parameter int CNT_W       = 8,
  parameter int LAT_SCHED   = 5,
  parameter int LAT_WRITE   = 4,
  parameter int LAT_READ    = 1,
  parameter int LAT_DESTROY = 2,
  parameter bit FAST        = 1'b0,
  localparam int SW         = $clog2(SLOTS),
  localparam int OFF_W      = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SW-1:0]     cmd_slot,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [CNT_W-1:0]  cmd_cnt,
  output logic              rsp_done,
  output logic [SW-1:0]     rsp_handle,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              rsp_nores,
  output logic              rdy_valid,
  input  logic              rdy_ready,
  output logic [SW-1:0]     rdy_slot,
  output logic [PTR_W-1:0]  rdy_ptr
);
  localparam int MEM_WORDS = SLOTS * FRAME_WORDS;
  localparam int LAT_MAX1  = (LAT_SCHED > LAT_WRITE) ? LAT_SCHED : LAT_WRITE;
  localparam int LAT_MAX2  = (LAT_READ > LAT_DESTROY) ? LAT_READ : LAT_DESTROY;
  localparam int LAT_MAX   = (LAT_MAX1 > LAT_MAX2) ? LAT_MAX1 : LAT_MAX2;
  localparam int LAT_W     = $clog2(LAT_MAX + 1);
  localparam int ENT_W     = SW + PTR_W;
  localparam int ADDR_W    = SW + OFF_W;

  // ---------------- command timing ----------------
  logic [LAT_W-1:0] lat_in;
  logic accept, fire_now, fire_late, fire;

  always_comb lat_in = LAT_W'(lat_of(cmd_op, FAST, LAT_SCHED, LAT_WRITE, LAT_READ, LAT_DESTROY));

  dft_cmd_timer #(.LAT_W(LAT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .lat(lat_in),
    .cmd_ready(cmd_ready), .accept(accept), .fire_now(fire_now), .fire_late(fire_late)
  );
  assign fire = fire_now || fire_late;

  // ---------------- command capture ----------------
  logic [1:0]        op_q;
  logic [SW-1:0]     slot_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic [PTR_W-1:0]  cptr_q;
  logic [CNT_W-1:0]  ccnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      slot_q <= '0;
      off_q  <= '0;
      data_q <= '0;
      cptr_q <= '0;
      ccnt_q <= '0;
    end else if (accept) begin
      op_q   <= cmd_op;
      slot_q <= cmd_slot;
      off_q  <= cmd_off;
      data_q <= cmd_data;
      cptr_q <= cmd_ptr;
      ccnt_q <= cmd_cnt;
    end
  end

  // Operands: live inputs for single-cycle commands, captured copy otherwise.
  logic [1:0]        op_x;
  logic [SW-1:0]     slot_x;
  logic [OFF_W-1:0]  off_x;
  logic [DATA_W-1:0] data_x;
  logic [PTR_W-1:0]  cptr_x;
  logic [CNT_W-1:0]  ccnt_x;

  assign op_x   = fire_now ? cmd_op   : op_q;
  assign slot_x = fire_now ? cmd_slot : slot_q;
  assign off_x  = fire_now ? cmd_off  : off_q;
  assign data_x = fire_now ? cmd_data : data_q;
  assign cptr_x = fire_now ? cmd_ptr  : cptr_q;
  assign ccnt_x = fire_now ? cmd_cnt  : ccnt_q;

  // ---------------- slot state ----------------
  logic [SLOTS-1:0] used_q, used_d;
  logic [CNT_W-1:0] pend_q [SLOTS];
  logic [CNT_W-1:0] pend_d [SLOTS];
  logic [PTR_W-1:0] code_q [SLOTS];
  logic [PTR_W-1:0] code_d [SLOTS];

  logic          free_found;
  logic [SW-1:0] free_idx;

  dft_slot_pick #(.SLOTS(SLOTS), .SW(SW)) u_pick (
    .used(used_q), .found(free_found), .idx(free_idx)
  );

  logic             cur_live;
  logic [CNT_W-1:0] cur_pend;
  assign cur_live = used_q[slot_x];
  assign cur_pend = pend_q[slot_x];

  // ---------------- frame storage ----------------
  logic [DATA_W-1:0] frame_mem [MEM_WORDS];
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  assign mem_addr = {slot_x, off_x};

  // ---------------- response and queue next state ----------------
  logic              done_q, err_q, err_d, nores_q, nores_d;
  logic [SW-1:0]     handle_q, handle_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              q_push;
  logic [ENT_W-1:0]  q_entry, q_head;

  always_comb begin
    used_d   = used_q;
    pend_d   = pend_q;
    code_d   = code_q;
    err_d    = 1'b0;
    nores_d  = 1'b0;
    handle_d = handle_q;
    rdata_d  = rdata_q;
    mem_we   = 1'b0;
    q_push   = 1'b0;
    q_entry  = '0;
    if (fire) begin
      case (op_x)
        OP_SCHED: begin
          if (free_found) begin
            used_d[free_idx] = 1'b1;
            pend_d[free_idx] = ccnt_x;
            code_d[free_idx] = cptr_x;
            handle_d         = free_idx;
            if (ccnt_x == '0) begin
              q_push  = 1'b1;
              q_entry = {free_idx, cptr_x};
            end
          end else begin
            nores_d = 1'b1;
          end
        end
        OP_WRITE: begin
          if (cur_live && (cur_pend != '0)) begin
            mem_we         = 1'b1;
            pend_d[slot_x] = cur_pend - CNT_W'(1);
            if (cur_pend == CNT_W'(1)) begin
              q_push  = 1'b1;
              q_entry = {slot_x, code_q[slot_x]};
            end
          end else begin
            err_d = 1'b1;
          end
        end
        OP_READ: begin
          if (cur_live) rdata_d = frame_mem[mem_addr];
          else begin
            rdata_d = '0;
            err_d   = 1'b1;
          end
        end
        default: begin
          if (cur_live) used_d[slot_x] = 1'b0;
          else          err_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        pend_q[i] <= '0;
        code_q[i] <= '0;
      end
    end else if (fire) begin
      used_q <= used_d;
      pend_q <= pend_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      nores_q  <= 1'b0;
      handle_q <= '0;
      rdata_q  <= '0;
    end else begin
      done_q  <= fire;
      err_q   <= err_d;
      nores_q <= nores_d;
      if (fire) begin
        handle_q <= handle_d;
        rdata_q  <= rdata_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) frame_mem[mem_addr] <= data_x;
  end

  dft_ready_fifo #(.DEPTH(SLOTS), .W(ENT_W)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_entry),
    .pop(rdy_ready), .out_valid(rdy_valid), .out_data(q_head)
  );

  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
  assign rsp_nores  = nores_q;
  assign rsp_handle = handle_q;
  assign rsp_data   = rdata_q;
  assign rdy_slot   = q_head[ENT_W-1:PTR_W];
  assign rdy_ptr    = q_head[PTR_W-1:0];
endmodule

// File: rtl/dft_sched_chk.sv
module dft_sched_chk #(
  parameter bit FAST  = 1'b0,
  parameter int SW    = 4,
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             rsp_done,
  input logic             rsp_err,
  input logic             rsp_nores,
  input logic             rdy_valid,
  input logic             rdy_ready,
  input logic [SW-1:0]    rdy_slot,
  input logic [PTR_W-1:0] rdy_ptr
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R8
  sched_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0 && !FAST) |=> !cmd_ready);

  // R8
  destroy_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3 && !FAST) |=> (!rsp_done ##1 rsp_done));

  // R8
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd2) |=> rsp_done);

  // R9
  fast_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && FAST) |=> rsp_done);

  // R6
  nores_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nores |-> (rsp_done && !rsp_err));

  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && !rdy_ready) |=> (rdy_valid && $stable(rdy_slot) && $stable(rdy_ptr)));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (cmd_ready && !rdy_valid && !rsp_done);
    end
  end
endmodule

bind dft_sched dft_sched_chk #(.FAST(FAST), .SW(SW), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_nores(rsp_nores),
  .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_slot(rdy_slot), .rdy_ptr(rdy_ptr)
);

// File: tb/sim_dft_sched.sv
`timescale 1ns/1ps
module sim_dft_sched;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic [1:0]  c_op;
  logic [3:0]  c_slot;
  logic [5:0]  c_off;
  logic [63:0] c_data;
  logic [31:0] c_ptr;
  logic [7:0]  c_cnt;
  logic v0, v1, rr0;

  logic r0_rdy, d0, e0, n0, q0v;
  logic [3:0] h0, q0s;
  logic [63:0] dat0;
  logic [31:0] q0p;
  logic r1_rdy, d1, e1, n1, q1v;
  logic [3:0] h1, q1s;
  logic [63:0] dat1;
  logic [31:0] q1p;

  dft_sched u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v0), .cmd_ready(r0_rdy), .cmd_op(c_op),
    .cmd_slot(c_slot), .cmd_off(c_off), .cmd_data(c_data), .cmd_ptr(c_ptr), .cmd_cnt(c_cnt),
    .rsp_done(d0), .rsp_handle(h0), .rsp_data(dat0), .rsp_err(e0), .rsp_nores(n0),
    .rdy_valid(q0v), .rdy_ready(rr0), .rdy_slot(q0s), .rdy_ptr(q0p)
  );

  dft_sched #(.FAST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v1), .cmd_ready(r1_rdy), .cmd_op(c_op),
    .cmd_slot(c_slot), .cmd_off(c_off), .cmd_data(c_data), .cmd_ptr(c_ptr), .cmd_cnt(c_cnt),
    .rsp_done(d1), .rsp_handle(h1), .rsp_data(dat1), .rsp_err(e1), .rsp_nores(n1),
    .rdy_valid(q1v), .rdy_ready(1'b1), .rdy_slot(q1s), .rdy_ptr(q1p)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Response captured at the done cycle.
  int g_lat;
  bit g_early;
  logic [3:0] g_h;
  logic [63:0] g_d;
  logic g_e, g_n;

  task automatic do_cmd(input bit sel, input logic [1:0] op, input logic [3:0] slot,
                        input logic [5:0] off, input logic [63:0] data,
                        input logic [31:0] ptr, input logic [7:0] cnt);
    @(negedge clk);
    while (!(sel ? r1_rdy : r0_rdy)) @(negedge clk);
    c_op = op; c_slot = slot; c_off = off; c_data = data; c_ptr = ptr; c_cnt = cnt;
    if (sel) v1 = 1'b1; else v0 = 1'b1;
    @(posedge clk);
    g_lat = 1;
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    g_early = 1'b0;
    while (!(sel ? d1 : d0) && g_lat < 20) begin
      if (sel ? r1_rdy : r0_rdy) g_early = 1'b1;
      @(posedge clk);
      g_lat++;
      @(negedge clk);
    end
    g_h = sel ? h1 : h0;
    g_d = sel ? dat1 : dat0;
    g_e = sel ? e1 : e0;
    g_n = sel ? n1 : n0;
  endtask

  task automatic pop_expect(input logic [3:0] slot, input logic [31:0] ptr, input string req);
    @(negedge clk);
    chk(req, "queue valid", 64'(q0v), 64'd1);
    chk(req, "queue slot", 64'(q0s), 64'(slot));
    chk(req, "queue ptr", 64'(q0p), 64'(ptr));
    rr0 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rr0 = 1'b0;
  endtask

  function automatic int exp_lat(input logic [1:0] op);
    case (op)
      2'd0: return 5;
      2'd1: return 4;
      2'd2: return 1;
      default: return 2;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  slot;
    logic [5:0]  off;
    logic [63:0] data;
    logic [31:0] ptr;
    logic [7:0]  cnt;
    logic        xerr;
    logic        chk_h;
    logic [3:0]  xh;
    logic        chk_d;
    logic [63:0] xd;
  } vec_t;

  // op: 0 create, 1 write, 2 read, 3 destroy
  localparam vec_t VEC [14] = '{
    '{2'd0, 4'd0, 6'd0,  64'h0,                  32'hA0, 8'd2, 1'b0, 1'b1, 4'd0, 1'b0, 64'h0},                  // R1
    '{2'd0, 4'd0, 6'd0,  64'h0,                  32'hB0, 8'd1, 1'b0, 1'b1, 4'd1, 1'b0, 64'h0},                  // R1
    '{2'd0, 4'd0, 6'd0,  64'h0,                  32'hC0, 8'd0, 1'b0, 1'b1, 4'd2, 1'b0, 64'h0},                  // R4
    '{2'd1, 4'd0, 6'd5,  64'h1111_2222_3333_4444, 32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b0, 64'h0},                  // R3
    '{2'd1, 4'd1, 6'd63, 64'hDEAD_BEEF_0000_0063, 32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b0, 64'h0},                  // R3
    '{2'd1, 4'd0, 6'd0,  64'h0000_0000_0000_0ABC, 32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b0, 64'h0},                  // R3
    '{2'd1, 4'd1, 6'd63, 64'h5,                  32'h0,  8'd0, 1'b1, 1'b0, 4'd0, 1'b0, 64'h0},                  // R5
    '{2'd1, 4'd9, 6'd0,  64'h6,                  32'h0,  8'd0, 1'b1, 1'b0, 4'd0, 1'b0, 64'h0},                  // R5
    '{2'd2, 4'd0, 6'd5,  64'h0,                  32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b1, 64'h1111_2222_3333_4444}, // R3
    '{2'd2, 4'd1, 6'd63, 64'h0,                  32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b1, 64'hDEAD_BEEF_0000_0063}, // R5 no store
    '{2'd2, 4'd0, 6'd0,  64'h0,                  32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b1, 64'h0000_0000_0000_0ABC}, // R3
    '{2'd3, 4'd1, 6'd0,  64'h0,                  32'h0,  8'd0, 1'b0, 1'b0, 4'd0, 1'b0, 64'h0},                  // R7
    '{2'd3, 4'd1, 6'd0,  64'h0,                  32'h0,  8'd0, 1'b1, 1'b0, 4'd0, 1'b0, 64'h0},                  // R7
    '{2'd0, 4'd0, 6'd0,  64'h0,                  32'hD0, 8'd1, 1'b0, 1'b1, 4'd1, 1'b0, 64'h0}                   // R7 reuse
  };

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    v0 = 1'b0; v1 = 1'b0; rr0 = 1'b0;
    c_op = '0; c_slot = '0; c_off = '0; c_data = '0; c_ptr = '0; c_cnt = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 idle state after reset
    chk("R11", "cmd_ready", 64'(r0_rdy), 64'd1);
    chk("R11", "rdy_valid", 64'(q0v), 64'd0);
    chk("R11", "rsp_done", 64'(d0), 64'd0);
    chk("R11", "fast cmd_ready", 64'(r1_rdy), 64'd1);

    foreach (VEC[i]) begin
      do_cmd(1'b0, VEC[i].op, VEC[i].slot, VEC[i].off, VEC[i].data, VEC[i].ptr, VEC[i].cnt);
      chk("R8", $sformatf("latency vec %0d", i), 64'(g_lat), 64'(exp_lat(VEC[i].op)));
      chk("R8", $sformatf("ready held low vec %0d", i), 64'(g_early), 64'd0);
      chk(VEC[i].xerr ? "R5/R7" : "R1", $sformatf("err vec %0d", i), 64'(g_e), 64'(VEC[i].xerr));
      if (VEC[i].chk_h) chk("R1", $sformatf("handle vec %0d", i), 64'(g_h), 64'(VEC[i].xh));
      if (VEC[i].chk_d) chk("R3", $sformatf("read data vec %0d", i), g_d, VEC[i].xd);
    end

    // R10 head held while not popped, then order by count reaching zero
    @(negedge clk);
    chk("R10", "head slot before wait", 64'(q0s), 64'd2);
    repeat (3) @(negedge clk);
    chk("R10", "head slot held", 64'(q0s), 64'd2);
    pop_expect(4'd2, 32'hC0, "R4");
    pop_expect(4'd1, 32'hB0, "R10");
    pop_expect(4'd0, 32'hA0, "R10");
    @(negedge clk);
    chk("R5", "no extra queue entry", 64'(q0v), 64'd0);

    // R2 count of three needs three writes
    do_cmd(1'b0, 2'd0, 4'd0, 6'd0, 64'h0, 32'hE0, 8'd3);
    chk("R2", "handle", 64'(g_h), 64'd3);
    do_cmd(1'b0, 2'd1, 4'd3, 6'd1, 64'h11, 32'h0, 8'd0);
    do_cmd(1'b0, 2'd1, 4'd3, 6'd2, 64'h22, 32'h0, 8'd0);
    @(negedge clk);
    chk("R2", "not ready after two writes", 64'(q0v), 64'd0);
    do_cmd(1'b0, 2'd1, 4'd3, 6'd3, 64'h33, 32'h0, 8'd0);
    pop_expect(4'd3, 32'hE0, "R2");

    // R6 exhaust slots 4..15
    for (int k = 4; k < 16; k++) begin
      do_cmd(1'b0, 2'd0, 4'd0, 6'd0, 64'h0, 32'h100 + 32'(k), 8'd1);
      chk("R1", $sformatf("lowest free slot %0d", k), 64'(g_h), 64'(k));
    end
    do_cmd(1'b0, 2'd0, 4'd0, 6'd0, 64'h0, 32'hF0, 8'd1);
    chk("R6", "nores when full", 64'(g_n), 64'd1);
    do_cmd(1'b0, 2'd3, 4'd9, 6'd0, 64'h0, 32'h0, 8'd0);
    chk("R7", "destroy ok", 64'(g_e), 64'd0);
    do_cmd(1'b0, 2'd0, 4'd0, 6'd0, 64'h0, 32'hF1, 8'd1);
    chk("R7", "freed slot reused", 64'(g_h), 64'd9);
    chk("R6", "nores clear", 64'(g_n), 64'd0);
    do_cmd(1'b0, 2'd0, 4'd0, 6'd0, 64'h0, 32'hF2, 8'd1);
    chk("R6", "full again, nothing taken", 64'(g_n), 64'd1);

    // R9 optimistic instance, every command in one cycle
    do_cmd(1'b1, 2'd0, 4'd0, 6'd0, 64'h0, 32'h77, 8'd1);
    chk("R9", "create latency", 64'(g_lat), 64'd1);
    chk("R9", "create handle", 64'(g_h), 64'd0);
    do_cmd(1'b1, 2'd1, 4'd0, 6'd3, 64'hCAFE, 32'h0, 8'd0);
    chk("R9", "write latency", 64'(g_lat), 64'd1);
    do_cmd(1'b1, 2'd2, 4'd0, 6'd3, 64'h0, 32'h0, 8'd0);
    chk("R9", "read latency", 64'(g_lat), 64'd1);
    chk("R9", "read data", g_d, 64'hCAFE);
    do_cmd(1'b1, 2'd3, 4'd0, 6'd0, 64'h0, 32'h0, 8'd0);
    chk("R9", "destroy latency", 64'(g_lat), 64'd1);
    chk("R9", "destroy ok", 64'(g_e), 64'd0);

    finish_run();
  end
endmodule